// File: doc/BRIEF.md
# Interrupt Entry Context Sequencer

This block is the processor-side logic that turns a pending interrupt request into a change of control flow. It looks at the request line only when the pipeline reports a boundary between two instructions. It also requires that the status word does not block interrupts. When it takes the request, it stores the running status word and program counter in two shadow registers. It then gives the processor a new status word and a new fetch address.

The new status word sets three control bits: interrupt block, privileged mode and alternate register bank. The priority mask field and every other bit keep their current values. The new fetch address is a fixed offset of 0x600 above the vector base. It is delivered in the same cycle as the entry pulse, so the next instruction fetched is the first instruction of the handler. There is no delay slot.

A restore strobe does the reverse in a single cycle. It offers the saved status word and saved program counter back as the new context. Instruction decode and return-instruction handling sit outside the block.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry happens only when `irq_req` and `insn_brk` are both high on the same rising edge and `cur_sr` bit 28 is 0. On the next cycle `accept` is high for exactly one clock.
- R2: A request without the boundary strobe, or a boundary strobe without a request, causes no entry. `accept`, `ctx_load` and the saved registers stay unchanged.
- R3: On entry, `saved_sr` takes the value of `cur_sr` and `saved_pc` takes the value of `cur_pc`, both as sampled at the accepting edge.
- R4: On entry, `new_sr` has bit 28 (block), bit 29 (register bank) and bit 30 (privileged mode) set to 1.
- R5: On entry, the mask field `new_sr[7:4]` and every bit other than 28, 29 and 30 equal the sampled `cur_sr`.
- R6: On entry, `new_pc` equals `vbr + 32'h0000_0600` modulo 2^32. `ctx_load` is high in the same cycle as `accept`, so the redirect is not delayed.
- R7: While `cur_sr` bit 28 is 1, requests are ignored. No `accept` occurs and the saved registers keep their contents.
- R8: A `restore_stb` with no entry on the same edge gives, on the next cycle, `ctx_load` high, `accept` low, `new_sr` equal to `saved_sr` and `new_pc` equal to `saved_pc`.
- R9: After synchronous reset, `accept`, `ctx_load`, `new_sr`, `new_pc`, `saved_sr` and `saved_pc` are all 0.
- R10: When an entry and `restore_stb` fall on the same edge, the entry wins and the restore is dropped.
- R11: The vector sum wraps at 32 bits. For example, base 0xFFFF_FC00 gives fetch address 0x0000_0200.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Prioritised interrupt request from the controller |
| insn_brk | input | 1 | High in a cycle that lies between two instructions |
| cur_sr | input | 32 | Current status word |
| cur_pc | input | 32 | Program counter of the next instruction |
| vbr | input | 32 | Vector base address |
| restore_stb | input | 1 | Request to reinstate the saved context |
| accept | output | 1 | One-cycle pulse marking an interrupt entry |
| ctx_load | output | 1 | One-cycle pulse: load `new_sr` and fetch from `new_pc` |
| new_sr | output | 32 | Status word to load |
| new_pc | output | 32 | Address to fetch next |
| saved_sr | output | 32 | Shadow copy of the status word |
| saved_pc | output | 32 | Shadow copy of the program counter |

## Verification
Entry is tried with four request patterns: request alone, boundary alone, both together, and both together while the block bit is set. Together these separate the two-input qualification from the block-bit gate. The status word is driven with different fill patterns, including all ones and all zeros, so that a wrong forced bit or a disturbed mask field shows as a mismatch. Distinct vector bases, one of them near the top of the address space, expose adder and wrap errors. A restore on its own and a restore that collides with an entry show both the copy-back path and which of the two wins.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int XLEN = 32;

    // Status word control bit positions
    localparam int SR_BLK_POS  = 28;
    localparam int SR_BANK_POS = 29;
    localparam int SR_PRIV_POS = 30;
    localparam int SR_MASK_LO  = 4;
    localparam int SR_MASK_W   = 4;

    localparam logic [XLEN-1:0] HANDLER_OFS = 32'h0000_0600;

    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        word_t sr;
        word_t pc;
    } ctx_t;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_ENTER   = 2'd1,
        ACT_RESTORE = 2'd2
    } ctx_act_e;

    function automatic word_t bit_mask(input int pos);
        word_t m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_take_gate.sv
module irq_take_gate (
    input  logic clk,
    input  logic rst,
    input  logic irq_req,
    input  logic insn_brk,
    input  logic blk_bit,
    input  logic restore_stb,
    output irq_entry_pkg::ctx_act_e act,
    output logic accept
);
    import irq_entry_pkg::*;

    logic take;

    assign take = irq_req & insn_brk & ~blk_bit;

    always_comb begin
        if (take)
            act = ACT_ENTER;
        else if (restore_stb)
            act = ACT_RESTORE;
        else
            act = ACT_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            accept <= 1'b0;
        else
            accept <= (act == ACT_ENTER);
    end

    // R1
    accept_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(irq_req) && $past(insn_brk));

    // R7
    blocked_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        $past(blk_bit) |-> !accept);

endmodule

// File: rtl/irq_ctx_shadow.sv
module irq_ctx_shadow (
    input  logic clk,
    input  logic rst,
    input  irq_entry_pkg::ctx_act_e act,
    input  irq_entry_pkg::ctx_t live_ctx,
    input  logic accept,
    output irq_entry_pkg::ctx_t shadow_ctx
);
    import irq_entry_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)
            shadow_ctx <= '0;
        else if (act == ACT_ENTER)
            shadow_ctx <= live_ctx;
    end

    // R3
    save_ctx_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> shadow_ctx == $past(live_ctx));

    // R2
    hold_ctx_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |-> $stable(shadow_ctx));

endmodule

// File: rtl/irq_vector_out.sv
module irq_vector_out #(
    parameter logic [irq_entry_pkg::XLEN-1:0] VEC_OFS = irq_entry_pkg::HANDLER_OFS
) (
    input  logic clk,
    input  logic rst,
    input  irq_entry_pkg::ctx_act_e act,
    input  irq_entry_pkg::word_t cur_sr,
    input  irq_entry_pkg::word_t vbr,
    input  irq_entry_pkg::ctx_t shadow_ctx,
    input  logic accept,
    output irq_entry_pkg::ctx_t next_ctx,
    output logic ctx_load
);
    import irq_entry_pkg::*;

    word_t force_mask;
    ctx_t  enter_ctx;

    for (genvar i = 0; i < XLEN; i++) begin : g_force
        assign force_mask[i] = (i == SR_BLK_POS) || (i == SR_BANK_POS) || (i == SR_PRIV_POS);
    end

    assign enter_ctx.sr = cur_sr | force_mask;
    assign enter_ctx.pc = vbr + VEC_OFS;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_ctx <= '0;
            ctx_load <= 1'b0;
        end else begin
            unique case (act)
                ACT_ENTER: begin
                    next_ctx <= enter_ctx;
                    ctx_load <= 1'b1;
                end
                ACT_RESTORE: begin
                    next_ctx <= shadow_ctx;
                    ctx_load <= 1'b1;
                end
                default: ctx_load <= 1'b0;
            endcase
        end
    end

    // R4
    force_bits_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> next_ctx.sr[SR_BLK_POS] && next_ctx.sr[SR_BANK_POS] && next_ctx.sr[SR_PRIV_POS]);

    // R5
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> next_ctx.sr[SR_MASK_LO +: SR_MASK_W] == $past(cur_sr[SR_MASK_LO +: SR_MASK_W]));

    // R6
    vec_addr_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> ctx_load && next_ctx.pc == $past(vbr) + VEC_OFS);

    // R8
    restore_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_load && !accept) |-> next_ctx == shadow_ctx);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter logic [31:0] VEC_OFS = irq_entry_pkg::HANDLER_OFS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_req,
    input  logic        insn_brk,
    input  logic [31:0] cur_sr,
    input  logic [31:0] cur_pc,
    input  logic [31:0] vbr,
    input  logic        restore_stb,
    output logic        accept,
    output logic        ctx_load,
    output logic [31:0] new_sr,
    output logic [31:0] new_pc,
    output logic [31:0] saved_sr,
    output logic [31:0] saved_pc
);
    import irq_entry_pkg::*;

    ctx_act_e act;
    ctx_t     live_ctx;
    ctx_t     shadow_ctx;
    ctx_t     next_ctx;

    assign live_ctx.sr = cur_sr;
    assign live_ctx.pc = cur_pc;

    irq_take_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .irq_req    (irq_req),
        .insn_brk   (insn_brk),
        .blk_bit    (cur_sr[SR_BLK_POS]),
        .restore_stb(restore_stb),
        .act        (act),
        .accept     (accept)
    );

    irq_ctx_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .live_ctx  (live_ctx),
        .accept    (accept),
        .shadow_ctx(shadow_ctx)
    );

    irq_vector_out #(.VEC_OFS(VEC_OFS)) u_vec (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .cur_sr    (cur_sr),
        .vbr       (vbr),
        .shadow_ctx(shadow_ctx),
        .accept    (accept),
        .next_ctx  (next_ctx),
        .ctx_load  (ctx_load)
    );

    assign new_sr   = next_ctx.sr;
    assign new_pc   = next_ctx.pc;
    assign saved_sr = shadow_ctx.sr;
    assign saved_pc = shadow_ctx.pc;

endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic        insn_brk = 1'b0;
    logic [31:0] cur_sr = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] vbr = '0;
    logic        restore_stb = 1'b0;
    logic        accept, ctx_load;
    logic [31:0] new_sr, new_pc, saved_sr, saved_pc;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] FORCE = 32'h7000_0000;

    always #2.5 clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .insn_brk(insn_brk),
        .cur_sr(cur_sr), .cur_pc(cur_pc), .vbr(vbr), .restore_stb(restore_stb),
        .accept(accept), .ctx_load(ctx_load), .new_sr(new_sr), .new_pc(new_pc),
        .saved_sr(saved_sr), .saved_pc(saved_pc)
    );

    task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
        end
    endtask

    task automatic idle_inputs();
        irq_req = 1'b0; insn_brk = 1'b0; restore_stb = 1'b0;
    endtask

    // Drive on a negedge, result visible at the next negedge
    task automatic do_entry(input logic [31:0] sr, input logic [31:0] pc, input logic [31:0] base);
        @(negedge clk);
        cur_sr = sr; cur_pc = pc; vbr = base; irq_req = 1'b1; insn_brk = 1'b1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        chk("R9 accept",   {31'b0, accept},   32'h0);
        chk("R9 ctx_load", {31'b0, ctx_load}, 32'h0);
        chk("R9 new_sr",   new_sr,   32'h0);
        chk("R9 new_pc",   new_pc,   32'h0);
        chk("R9 saved_sr", saved_sr, 32'h0);
        chk("R9 saved_pc", saved_pc, 32'h0);
    endtask

    task automatic t_half_inputs();
        @(negedge clk);
        cur_sr = 32'h0000_00A0; cur_pc = 32'h1111_2222; irq_req = 1'b1; insn_brk = 1'b0;
        @(negedge clk);
        chk("R2 req only accept", {31'b0, accept}, 32'h0);
        chk("R2 req only load",   {31'b0, ctx_load}, 32'h0);
        irq_req = 1'b0; insn_brk = 1'b1;
        @(negedge clk);
        chk("R2 brk only accept", {31'b0, accept}, 32'h0);
        chk("R2 saved_pc held",   saved_pc, 32'h0);
        idle_inputs();
    endtask

    task automatic t_entry(input logic [31:0] sr, input logic [31:0] pc, input logic [31:0] base);
        do_entry(sr, pc, base);
        chk("R1 accept pulse", {31'b0, accept}, 32'h1);
        chk("R6 ctx_load same cycle", {31'b0, ctx_load}, 32'h1);
        chk("R3 saved_sr", saved_sr, sr);
        chk("R3 saved_pc", saved_pc, pc);
        chk("R4 forced bits", new_sr & FORCE, FORCE);
        chk("R5 other bits", new_sr & ~FORCE, sr & ~FORCE);
        chk("R5 mask field", {28'b0, new_sr[7:4]}, {28'b0, sr[7:4]});
        chk("R6 new_pc", new_pc, base + 32'h600);
        @(negedge clk);
        chk("R1 accept one clock", {31'b0, accept}, 32'h0);
        chk("R6 ctx_load one clock", {31'b0, ctx_load}, 32'h0);
    endtask

    task automatic t_blocked();
        logic [31:0] ssr, spc;
        ssr = saved_sr; spc = saved_pc;
        do_entry(32'h1000_00F0, 32'hDEAD_0000, 32'h0000_4000);
        chk("R7 blocked accept", {31'b0, accept}, 32'h0);
        chk("R7 blocked load",   {31'b0, ctx_load}, 32'h0);
        chk("R7 saved_sr held",  saved_sr, ssr);
        chk("R7 saved_pc held",  saved_pc, spc);
    endtask

    task automatic t_restore();
        logic [31:0] ssr, spc;
        ssr = saved_sr; spc = saved_pc;
        @(negedge clk);
        cur_sr = 32'h7000_0000; restore_stb = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk("R8 restore load",   {31'b0, ctx_load}, 32'h1);
        chk("R8 restore accept", {31'b0, accept}, 32'h0);
        chk("R8 restore sr",     new_sr, ssr);
        chk("R8 restore pc",     new_pc, spc);
    endtask

    task automatic t_collide();
        @(negedge clk);
        cur_sr = 32'h0000_0050; cur_pc = 32'h0BAD_F00D; vbr = 32'h0010_0000;
        irq_req = 1'b1; insn_brk = 1'b1; restore_stb = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk("R10 entry wins accept", {31'b0, accept}, 32'h1);
        chk("R10 entry wins pc", new_pc, 32'h0010_0600);
        chk("R10 entry wins sr", new_sr, 32'h7000_0050);
        chk("R10 saved_pc", saved_pc, 32'h0BAD_F00D);
    endtask

    task automatic t_wrap();
        do_entry(32'h0000_0000, 32'h0000_0100, 32'hFFFF_FC00);
        chk("R11 wrapped pc", new_pc, 32'h0000_0200);
        chk("R11 accept", {31'b0, accept}, 32'h1);
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_half_inputs();
        t_entry(32'h0000_00F0, 32'h8000_1234, 32'h8000_0000);
        t_entry(32'h8FFF_FFFF, 32'h0000_ABCC, 32'h0C00_0000);
        t_blocked();
        t_restore();
        t_entry(32'h0000_0030, 32'h4444_0008, 32'h0000_1000);
        t_restore();
        t_collide();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule